// File: doc/BRIEF.md
# Half-Word to Word Register Access Combiner

This block joins a 16-bit host to a register space that only accepts 32-bit accesses. The host issues accesses of either half-word or full-word size. Two half-word writes to the same 32-bit word are merged into one 32-bit downstream write. The first half-word read of a word triggers one 32-bit downstream read, and the result is kept in a latch. The second half-word read of that word is served from the latch. A register that pops a FIFO on read is therefore read only once for each pair of half-word reads.

The host request side uses valid/ready. An access is accepted in a cycle where `h_valid` and `h_ready` are both high. While `h_ready` is low the host must hold its request stable. `h_ready` drops for exactly one cycle after every downstream read. Each accepted access produces one response pulse on `rsp_valid` in the following cycle. The response has no back-pressure, so the host must take it in that cycle.

The downstream side is a plain request/strobe bus:
- `d_req` is driven combinationally in the cycle the host access is accepted.
- For a write, the data on `d_wdata` is taken with `d_req`.
- For a read, `d_rdata` is valid in the cycle after `d_req`.

Top module: `hwc_combiner`

## Requirements
- R1: Address bit 1 selects the half. A half-word write with bit 1 set lands in bits 31:16 of the merged word, and with bit 1 clear it lands in bits 15:0. A half-word read returns the selected half on `rsp_data[15:0]`, with `rsp_data[31:16]` zero. Half-word write data is taken from `h_wdata[15:0]`.
- R2: The second of two consecutive half-word writes to the same word issues exactly one downstream write of {high latch, low latch} to the word address (bits 1:0 zero), in the cycle it is accepted. The first write issues nothing.
- R3: A half-word write to a word address other than the last half-word write's word restarts write pairing. That access counts as a first half and issues no downstream write.
- R4: The first half-word read of a word issues one downstream read of the word address in its accept cycle. The response in the next cycle carries the selected half of `d_rdata`, and `h_ready` is low in that same next cycle.
- R5: The second half-word read of a pair issues no downstream request and returns the selected half of the latched word. Read pairing then restarts, so a third read of the same word issues a new downstream read.
- R6: A half-word read of a word other than the last half-word read's word restarts read pairing and issues a new downstream read.
- R7: A full-word access (size code 2, address bits 1:0 zero) passes straight through:
  - A write issues a downstream write of `h_wdata` in the accept cycle.
  - A read issues a downstream read and returns all 32 bits of `d_rdata` in the next cycle.
  - Neither kind changes the half-word pairing state or the read latch.
- R8: An access is an error if its size code is neither 1 (half-word) nor 2 (word), if it is a half-word with address bit 0 set, or if it is a word with address bits 1:0 non-zero. An erroneous access:
  - issues no downstream request;
  - responds with `rsp_err`=1 and `rsp_data`=0;
  - leaves the pairing state unchanged.
- R9: Every accepted access gets exactly one `rsp_valid` pulse, in the cycle after acceptance. Valid writes respond with `rsp_err`=0 and `rsp_data`=0.
- R10: After reset:
  - `h_ready` is 1, and `rsp_valid` and `d_req` are 0;
  - neither path has a remembered word, so the first half-word access is always a first half;
  - the write half latches hold zero, so two high-half writes to one word give {second data, 16'h0000}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host access request valid |
| h_ready | output | 1 | Block can accept an access this cycle |
| h_write | input | 1 | 1 = write, 0 = read |
| h_size | input | 2 | Size code: 1 = half-word, 2 = word, other = error |
| h_addr | input | AW | Byte address |
| h_wdata | input | DW | Write data (half-word in bits 15:0) |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_data | output | DW | Read data (half-word zero-extended) |
| rsp_err | output | 1 | Access was erroneous |
| d_req | output | 1 | Downstream access strobe |
| d_we | output | 1 | Downstream write enable |
| d_addr | output | AW | Downstream word address |
| d_wdata | output | DW | Downstream write data |
| d_rdata | input | DW | Downstream read data, valid the cycle after a read strobe |

## Verification
Each downstream strobe, with its address, write enable and data, appears in the same cycle the host access is accepted. The response pulse, and `h_ready` going low after a downstream read, both appear exactly one cycle later. The bench drives every access on a falling edge and samples the downstream outputs one time unit later, before the accepting rising edge. It samples the response and `h_ready` at the next falling edge. The bench's downstream model returns data carrying a running count of the reads it has served. An extra or missing downstream read therefore changes every later expected read value.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Where the next response takes its data from
  typedef enum logic [1:0] {
    RS_NONE,
    RS_DN_HALF,
    RS_DN_WORD,
    RS_LATCH
  } rsp_src_e;
endpackage

// File: rtl/hwc_pair_track.sv
// Remembers the last word index seen on one path and whether the next
// access to that word completes a pair.
module hwc_pair_track #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [IW-1:0] idx,
  output logic          second
);
  logic [IW-1:0] prev_q;
  logic          prev_vld_q;
  logic          half_seen_q;

  assign second = prev_vld_q && (prev_q == idx) && half_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q      <= '0;
      prev_vld_q  <= 1'b0;
      half_seen_q <= 1'b0;
    end else if (step) begin
      prev_q      <= idx;
      prev_vld_q  <= 1'b1;
      half_seen_q <= !second;
    end
  end
endmodule

// File: rtl/hwc_wr_join.sv
// Holds the two write halves and presents the merged word.
module hwc_wr_join #(
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               sel_hi,
  input  logic [DW/2-1:0]    half_in,
  output logic [DW-1:0]      joined
);
  localparam int HW = DW / 2;

  logic [HW-1:0] lo_q;
  logic [HW-1:0] hi_q;

  assign joined = sel_hi ? {half_in, lo_q} : {hi_q, half_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (step) begin
      if (sel_hi) hi_q <= half_in;
      else        lo_q <= half_in;
    end
  end
endmodule

// File: rtl/hwc_rd_return.sv
// Response stage: one pulse per accepted access, read latch, busy flag.
module hwc_rd_return
  import hwc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  rsp_src_e      src_in,
  input  logic          sel_hi,
  input  logic          err_in,
  input  logic [DW-1:0] dn_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          busy
);
  localparam int HW = DW / 2;

  logic          vld_q;
  rsp_src_e      src_q;
  logic          hi_q;
  logic          err_q;
  logic [DW-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      src_q   <= RS_NONE;
      hi_q    <= 1'b0;
      err_q   <= 1'b0;
      latch_q <= '0;
    end else begin
      vld_q <= accept;
      if (accept) begin
        src_q <= src_in;
        hi_q  <= sel_hi;
        err_q <= err_in;
      end
      if (vld_q && src_q == RS_DN_HALF) latch_q <= dn_rdata;
    end
  end

  always_comb begin
    rsp_data = '0;
    if (vld_q) begin
      case (src_q)
        RS_DN_HALF: rsp_data = {{HW{1'b0}}, hi_q ? dn_rdata[DW-1:HW] : dn_rdata[HW-1:0]};
        RS_DN_WORD: rsp_data = dn_rdata;
        RS_LATCH:   rsp_data = {{HW{1'b0}}, hi_q ? latch_q[DW-1:HW] : latch_q[HW-1:0]};
        default:    rsp_data = '0;
      endcase
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_err   = vld_q && err_q;
  assign busy      = vld_q && (src_q == RS_DN_HALF || src_q == RS_DN_WORD);
endmodule

// File: rtl/hwc_combiner.sv
module hwc_combiner
  import hwc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_valid,
  output logic          h_ready,
  input  logic          h_write,
  input  logic [1:0]    h_size,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          d_req,
  output logic          d_we,
  output logic [AW-1:0] d_addr,
  output logic [DW-1:0] d_wdata,
  input  logic [DW-1:0] d_rdata
);
  localparam int IW = AW - 2;
  localparam int HW = DW / 2;
  localparam int NPATH = 2;   // index 0: write path, 1: read path

  logic          accept;
  logic          is_half;
  logic          is_word;
  logic          bad;
  logic          sel_hi;
  logic [IW-1:0] widx;
  logic          busy;
  logic [NPATH-1:0] trk_step;
  logic [NPATH-1:0] trk_second;
  logic [DW-1:0] joined;
  rsp_src_e      src;

  assign accept  = h_valid && h_ready;
  assign is_half = (h_size == SZ_HALF) && !h_addr[0];
  assign is_word = (h_size == SZ_WORD) && (h_addr[1:0] == 2'b00);
  assign bad     = !is_half && !is_word;
  assign sel_hi  = h_addr[1];
  assign widx    = h_addr[AW-1:2];

  assign trk_step[0] = accept && is_half && h_write;
  assign trk_step[1] = accept && is_half && !h_write;

  for (genvar g = 0; g < NPATH; g++) begin : g_trk
    hwc_pair_track #(.IW(IW)) trk_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (trk_step[g]),
      .idx    (widx),
      .second (trk_second[g])
    );
  end

  hwc_wr_join #(.DW(DW)) join_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (trk_step[0]),
    .sel_hi  (sel_hi),
    .half_in (h_wdata[HW-1:0]),
    .joined  (joined)
  );

  always_comb begin
    if (bad || h_write)   src = RS_NONE;
    else if (is_word)     src = RS_DN_WORD;
    else if (trk_second[1]) src = RS_LATCH;
    else                  src = RS_DN_HALF;
  end

  hwc_rd_return #(.DW(DW)) ret_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .src_in    (src),
    .sel_hi    (sel_hi),
    .err_in    (bad),
    .dn_rdata  (d_rdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err),
    .busy      (busy)
  );

  assign h_ready = !busy;
  assign d_req   = accept && (is_word ||
                              (trk_step[0] && trk_second[0]) ||
                              (trk_step[1] && !trk_second[1]));
  assign d_we    = h_write;
  assign d_addr  = {widx, 2'b00};
  assign d_wdata = is_word ? h_wdata : joined;
endmodule

// File: rtl/hwc_combiner_chk.sv
module hwc_combiner_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_valid,
  input logic          h_ready,
  input logic          h_write,
  input logic [1:0]    h_size,
  input logic [AW-1:0] h_addr,
  input logic [DW-1:0] h_wdata,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic          d_req,
  input logic          d_we,
  input logic [DW-1:0] d_wdata
);
  logic acc;
  logic acc_bad;
  assign acc     = h_valid && h_ready;
  assign acc_bad = acc && !((h_size == 2'd1 && !h_addr[0]) ||
                            (h_size == 2'd2 && h_addr[1:0] == 2'b00));

  // R9: one response, one cycle after acceptance
  p_rsp_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  p_no_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);
  // R4: host stalled one cycle after a downstream read
  p_stall_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_we) |=> !h_ready);
  // R8: erroneous access stays off the downstream bus and is flagged
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |-> !d_req);
  p_err_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> rsp_err);
  // R7: word write passes straight through
  p_word_write_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && h_write && h_size == 2'd2 && h_addr[1:0] == 2'b00)
      |-> (d_req && d_we && d_wdata == h_wdata));
  // R2: no downstream strobe without an accepted host access
  p_req_needs_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    d_req |-> acc);
endmodule

bind hwc_combiner hwc_combiner_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .h_valid   (h_valid),
  .h_ready   (h_ready),
  .h_write   (h_write),
  .h_size    (h_size),
  .h_addr    (h_addr),
  .h_wdata   (h_wdata),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .d_req     (d_req),
  .d_we      (d_we),
  .d_wdata   (d_wdata)
);

// File: tb/hwc_combiner_tb_top.sv
module hwc_combiner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          h_valid = 1'b0;
  logic          h_ready;
  logic          h_write = 1'b0;
  logic [1:0]    h_size = 2'd0;
  logic [AW-1:0] h_addr = '0;
  logic [DW-1:0] h_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          rsp_err;
  logic          d_req;
  logic          d_we;
  logic [AW-1:0] d_addr;
  logic [DW-1:0] d_wdata;
  logic [DW-1:0] d_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwc_combiner #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready),
    .h_write(h_write), .h_size(h_size), .h_addr(h_addr), .h_wdata(h_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
    .d_rdata(d_rdata)
  );

  // Downstream model: read data tags the served-read count and the address
  logic [15:0] dn_served = '0;
  always @(posedge clk) begin
    if (rst_n && d_req && !d_we) begin
      d_rdata   <= {dn_served, 8'h00, d_addr};
      dn_served <= dn_served + 16'd1;
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int cyc = 0;

  // Bench reference state
  bit          m_wvld, m_rvld, m_wcnt, m_rcnt;
  logic [5:0]  m_wprev, m_rprev;
  logic [15:0] m_wlo, m_whi;
  logic [31:0] m_rlatch;
  logic [15:0] m_rdcount;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_wvld = 0; m_rvld = 0; m_wcnt = 0; m_rcnt = 0;
    m_wprev = '0; m_rprev = '0; m_wlo = '0; m_whi = '0;
    m_rlatch = '0; m_rdcount = '0;
  endtask

  // One host access, checked against the reference
  task automatic acc(input bit wr, input logic [1:0] sz, input logic [7:0] a,
                     input logic [31:0] wd, input string tag);
    logic [5:0]  w;
    bit          half, word, bad, second, exp_req;
    logic [31:0] exp_wd, exp_rd, v;
    w = a[7:2];
    half = (sz == 2'd1) && !a[0];
    word = (sz == 2'd2) && (a[1:0] == 2'b00);
    bad = !half && !word;
    exp_req = 0; exp_wd = '0; exp_rd = '0;
    if (half && wr) begin
      second = m_wvld && m_wprev == w && m_wcnt;
      if (a[1]) m_whi = wd[15:0]; else m_wlo = wd[15:0];
      m_wvld = 1; m_wprev = w; m_wcnt = !second;
      if (second) begin exp_req = 1; exp_wd = {m_whi, m_wlo}; end
    end else if (half) begin
      second = m_rvld && m_rprev == w && m_rcnt;
      m_rvld = 1; m_rprev = w; m_rcnt = !second;
      if (!second) begin
        exp_req = 1;
        m_rlatch = {m_rdcount, 8'h00, w, 2'b00};
        m_rdcount = m_rdcount + 16'd1;
      end
      exp_rd = {16'h0, a[1] ? m_rlatch[31:16] : m_rlatch[15:0]};
    end else if (word) begin
      exp_req = 1;
      if (wr) exp_wd = wd;
      else begin
        v = {m_rdcount, 8'h00, w, 2'b00};
        m_rdcount = m_rdcount + 16'd1;
        exp_rd = v;
      end
    end
    while (!h_ready) @(negedge clk);
    h_valid = 1; h_write = wr; h_size = sz; h_addr = a; h_wdata = wd;
    #1;
    chk(d_req == exp_req, tag, "d_req", {31'b0, d_req}, {31'b0, exp_req});
    if (exp_req) begin
      chk(d_we == wr && d_addr == {w, 2'b00}, tag, "d_we/d_addr",
          {23'b0, d_we, d_addr}, {23'b0, wr, w, 2'b00});
      if (wr) chk(d_wdata == exp_wd, tag, "d_wdata", d_wdata, exp_wd);
    end
    @(negedge clk);
    h_valid = 0;
    #1;
    chk(rsp_valid == 1'b1 && rsp_err == bad, tag, "rsp_valid/rsp_err",
        {30'b0, rsp_valid, rsp_err}, {30'b0, 1'b1, bad});
    chk(rsp_data == exp_rd, tag, "rsp_data", rsp_data, exp_rd);
    if (exp_req && !wr)
      chk(h_ready == 1'b0, "R4", "h_ready stall", {31'b0, h_ready}, 32'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    model_reset();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(h_ready == 1'b1 && rsp_valid == 1'b0 && d_req == 1'b0, "R10", "reset outputs",
        {29'b0, h_ready, rsp_valid, d_req}, 32'h4);
    rst_n = 1;
    @(negedge clk);

    // R10: zero write latches after reset
    acc(1, 2'd1, 8'h06, 32'hFFFF_1111, "R10");
    acc(1, 2'd1, 8'h06, 32'h0000_2222, "R10");
    // R1 / R2: low then high, high then low
    acc(1, 2'd1, 8'h08, 32'h5555_AAAA, "R2");
    acc(1, 2'd1, 8'h0A, 32'h0000_BBBB, "R2");
    acc(1, 2'd1, 8'h0E, 32'h0000_C0DE, "R1");
    acc(1, 2'd1, 8'h0C, 32'h0000_F00D, "R1");
    // R3: a different word restarts write pairing
    acc(1, 2'd1, 8'h10, 32'h0000_1010, "R3");
    acc(1, 2'd1, 8'h14, 32'h0000_1414, "R3");
    acc(1, 2'd1, 8'h16, 32'h0000_1616, "R3");
    // R4 / R5: read pair, then a third read of the same word
    acc(0, 2'd1, 8'h22, '0, "R4");
    acc(0, 2'd1, 8'h20, '0, "R5");
    acc(0, 2'd1, 8'h20, '0, "R5");
    // R6: a different word restarts read pairing
    acc(0, 2'd1, 8'h24, '0, "R6");
    acc(0, 2'd1, 8'h28, '0, "R6");
    acc(0, 2'd1, 8'h2A, '0, "R6");
    // R7: word accesses leave pairing and the latch alone
    acc(0, 2'd1, 8'h30, '0, "R7");
    acc(0, 2'd2, 8'h30, '0, "R7");
    acc(0, 2'd1, 8'h32, '0, "R7");
    acc(1, 2'd2, 8'h34, 32'hDEAD_BEEF, "R7");
    acc(1, 2'd1, 8'h38, 32'h0000_3838, "R7");
    acc(1, 2'd2, 8'h3C, 32'h1234_5678, "R7");
    acc(1, 2'd1, 8'h3A, 32'h0000_3A3A, "R7");
    // R8: bad size codes and misaligned addresses between a pair
    acc(1, 2'd1, 8'h40, 32'h0000_4040, "R8");
    acc(1, 2'd0, 8'h44, 32'h0000_0BAD, "R8");
    acc(1, 2'd3, 8'h44, 32'h0000_0BAD, "R8");
    acc(1, 2'd1, 8'h41, 32'h0000_0BAD, "R8");
    acc(0, 2'd2, 8'h42, '0, "R8");
    acc(1, 2'd1, 8'h42, 32'h0000_4242, "R8");

    // R9: random mix of accesses over a few words
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [1:0] sz;
      logic [7:0] a;
      r = int'($urandom % 16);
      sz = (r < 11) ? 2'd1 : (r < 14) ? 2'd2 : (r == 14) ? 2'd0 : 2'd3;
      a = {4'b0, 2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 16 == 0)};
      acc(1'($urandom % 2), sz, a, $urandom, "R9");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule